// File: doc/BRIEF.md
# Speech Chip Bus Handshake Interface

This block sits between an 8-bit host peripheral bus and a parallel speech-synthesis chip. It has no address decode. A single register answers to every host read and every host write, whatever offset the host places on its address lines. The host strobes (`host_rd_n`, `host_wr_n`) and the chip's ready line are brought into the system clock domain through multi-stage synchronisers. Edges are detected only after synchronisation, so each access acts exactly once, however long the strobe is held.

On the read side, a flag reverses itself when every host read ends, and it drives the chip's active-low read-select pin. A read that finds the flag low returns the chip status with its five low bits forced to one. A read that finds the flag high returns the all-ones value the bus pull-ups would give. Host software therefore reads twice: the first read starts a status fetch, and the second read returns the status.

On the write side, a host write loads a byte into the chip data latch and lowers the chip's write-select. Write-select stays low until the chip's ready line falls. A new write that arrives before that point replaces the pending byte and raises a one-cycle overrun pulse.

Top module: `speech_bus_bridge`

## Requirements
- R1: While `rst_n` is low, and after it is released, `chip_rs_n`=1, `chip_ws_n`=1, `wr_idle`=1, `chip_data`=0xFF, `host_rdata`=0xFF and `overrun`=0.
- R2: At the start of a host read (falling `host_rd_n`), `host_rdata` captures `chip_status | 0x1F` if `chip_rs_n` is 0, or 0xFF if `chip_rs_n` is 1. It holds that value until the next read starts.
- R3: `chip_rs_n` inverts once at the end of each host read (rising `host_rd_n`) and changes at no other time except reset.
- R4: After reset, the first host read returns 0xFF, and the second returns the chip status with bits 4..0 set.
- R5: At the start of a host write (falling `host_wr_n`), `chip_data` takes `host_wdata` and `chip_ws_n` goes to 0.
- R6: A falling edge on `chip_ready_n` sets `chip_ws_n` to 1 and leaves `chip_data` unchanged. A rising edge on `chip_ready_n`, or a falling edge with no write pending, leaves `chip_ws_n` as it was.
- R7: A host write that starts while `chip_ws_n` is 0 replaces `chip_data` and raises `overrun` for exactly one clock. A write that starts while `chip_ws_n` is 1 raises no overrun.
- R8: `wr_idle` always equals the write flag that drives `chip_ws_n`, so it is 0 exactly while a written byte waits for the chip.
- R9: A host strobe held low for many clocks is counted as one access: one captured read value and one flip of `chip_rs_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| host_rd_n | input | 1 | Host read strobe, active low, asynchronous |
| host_wr_n | input | 1 | Host write strobe, active low, asynchronous |
| host_wdata | input | 8 | Host write data, stable while the write strobe is low |
| host_rdata | output | 8 | Value captured for the host at read start |
| chip_data | output | 8 | Data latch toward the speech chip |
| chip_rs_n | output | 1 | Chip read-select, active low |
| chip_ws_n | output | 1 | Chip write-select, active low |
| chip_ready_n | input | 1 | Chip ready, active low, asynchronous |
| chip_status | input | 8 | Chip status bus |
| overrun | output | 1 | One-cycle pulse when a pending byte is overwritten |
| wr_idle | output | 1 | Mirror of the write flag (1 = no byte pending) |

## Verification
Reads are issued back to back with two different status patterns (0xA0 and 0x40). The alternation shows whether the status path or the pull-up path is selected on each read, and the two patterns show whether the low-bit forcing is applied. A read held low for forty clocks shows whether the flag flips once or repeatedly. On the write side, the ready line is exercised with a falling edge while nothing is pending, with a rising edge while a byte is pending, and with a falling edge that completes a handshake; these separate a real release from a spurious one. Two writes in a row, followed by a write after release, show whether overrun fires only on a real overwrite. A reset applied mid-sequence shows that both flags return to their preset values.

// File: rtl/speech_bridge_pkg.sv
package speech_bridge_pkg;

    localparam int unsigned BUS_W       = 8;
    localparam int unsigned FORCED_LOW  = 5;
    localparam logic [BUS_W-1:0] PULLUP_VAL = {BUS_W{1'b1}};
    localparam logic [BUS_W-1:0] FORCE_MASK = BUS_W'((1 << FORCED_LOW) - 1);

    typedef struct packed {
        logic             sel_n;
        logic [BUS_W-1:0] rdata;
    } rd_state_t;

    typedef struct packed {
        logic             idle;
        logic [BUS_W-1:0] data;
        logic             ovr;
    } wr_state_t;

endpackage

// File: rtl/speech_sync_edge.sv
module speech_sync_edge #(
    parameter int unsigned STAGES   = 2,
    parameter logic        IDLE_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic fall,
    output logic rise
);
    localparam int unsigned TOP = STAGES - 1;

    logic [STAGES-1:0] chain_d, chain_q;
    logic              prev_d, prev_q;

    always_comb begin
        chain_d[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
        prev_d = chain_q[TOP];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{IDLE_LVL}};
            prev_q  <= IDLE_LVL;
        end else begin
            chain_q <= chain_d;
            prev_q  <= prev_d;
        end
    end

    assign fall = prev_q & ~chain_q[TOP];
    assign rise = ~prev_q & chain_q[TOP];

endmodule

// File: rtl/speech_read_path.sv
module speech_read_path
    import speech_bridge_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_lead,
    input  logic             rd_trail,
    input  logic [BUS_W-1:0] status,
    output logic [BUS_W-1:0] rdata,
    output logic             sel_n
);
    rd_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_lead) begin
            st_d.rdata = st_q.sel_n ? PULLUP_VAL : (status | FORCE_MASK);
        end
        if (rd_trail) begin
            st_d.sel_n = ~st_q.sel_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sel_n <= 1'b1;
            st_q.rdata <= PULLUP_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.rdata;
    assign sel_n = st_q.sel_n;

endmodule

// File: rtl/speech_write_path.sv
module speech_write_path
    import speech_bridge_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_lead,
    input  logic             rdy_fall,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] data,
    output logic             idle,
    output logic             ovr
);
    wr_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.ovr = 1'b0;
        if (rdy_fall) begin
            st_d.idle = 1'b1;
        end
        // a new byte outranks a simultaneous release
        if (wr_lead) begin
            st_d.data = wdata;
            st_d.idle = 1'b0;
            st_d.ovr  = ~st_q.idle;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.idle <= 1'b1;
            st_q.data <= PULLUP_VAL;
            st_q.ovr  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data = st_q.data;
    assign idle = st_q.idle;
    assign ovr  = st_q.ovr;

endmodule

// File: rtl/speech_bus_bridge.sv
module speech_bus_bridge
    import speech_bridge_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_rd_n,
    input  logic             host_wr_n,
    input  logic [BUS_W-1:0] host_wdata,
    output logic [BUS_W-1:0] host_rdata,
    output logic [BUS_W-1:0] chip_data,
    output logic             chip_rs_n,
    output logic             chip_ws_n,
    input  logic             chip_ready_n,
    input  logic [BUS_W-1:0] chip_status,
    output logic             overrun,
    output logic             wr_idle
);
    localparam int unsigned N_SYNC = 3;
    localparam int unsigned IX_RD  = 0;
    localparam int unsigned IX_WR  = 1;
    localparam int unsigned IX_RDY = 2;

    logic [N_SYNC-1:0] raw_in, edge_fall, edge_rise;

    assign raw_in = {chip_ready_n, host_wr_n, host_rd_n};

    for (genvar g = 0; g < N_SYNC; g++) begin : g_sync
        speech_sync_edge #(
            .STAGES  (SYNC_STAGES),
            .IDLE_LVL(1'b1)
        ) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_in(raw_in[g]),
            .fall    (edge_fall[g]),
            .rise    (edge_rise[g])
        );
    end

    logic rd_lead, rd_trail, wr_lead, wr_trail, rdy_fall, rdy_rise;
    assign rd_lead  = edge_fall[IX_RD];
    assign rd_trail = edge_rise[IX_RD];
    assign wr_lead  = edge_fall[IX_WR];
    assign wr_trail = edge_rise[IX_WR];
    assign rdy_fall = edge_fall[IX_RDY];
    assign rdy_rise = edge_rise[IX_RDY];

    logic wr_flag;

    speech_read_path u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_lead (rd_lead),
        .rd_trail(rd_trail),
        .status  (chip_status),
        .rdata   (host_rdata),
        .sel_n   (chip_rs_n)
    );

    speech_write_path u_wr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_lead (wr_lead),
        .rdy_fall(rdy_fall),
        .wdata   (host_wdata),
        .data    (chip_data),
        .idle    (wr_flag),
        .ovr     (overrun)
    );

    assign chip_ws_n = wr_flag;
    assign wr_idle   = wr_flag;

endmodule

// File: rtl/speech_bridge_checker.sv
module speech_bridge_checker
    import speech_bridge_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             rd_lead,
    input logic             rd_trail,
    input logic             wr_lead,
    input logic             wr_trail,
    input logic             rdy_fall,
    input logic             rdy_rise,
    input logic [BUS_W-1:0] chip_status,
    input logic [BUS_W-1:0] host_rdata,
    input logic [BUS_W-1:0] chip_data,
    input logic             chip_rs_n,
    input logic             chip_ws_n,
    input logic             overrun
);
    AST_RD_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lead && !chip_rs_n) |=> host_rdata == ($past(chip_status) | FORCE_MASK)); // R2
    AST_RD_PULLUP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lead && chip_rs_n) |=> host_rdata == PULLUP_VAL); // R2
    AST_RS_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        rd_trail |=> chip_rs_n != $past(chip_rs_n)); // R3
    AST_RS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_trail |=> $stable(chip_rs_n)); // R3
    AST_WS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lead |=> !chip_ws_n); // R5
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_trail || rdy_fall) |=> $stable(chip_data)); // R6
    AST_WS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_fall && !wr_lead) |=> chip_ws_n); // R6
    AST_RDY_RISE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_rise && !wr_lead) |=> $stable(chip_ws_n)); // R6
    AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> !$past(chip_ws_n)); // R7
    AST_OVR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> !overrun); // R7
endmodule

bind speech_bus_bridge speech_bridge_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_lead    (rd_lead),
    .rd_trail   (rd_trail),
    .wr_lead    (wr_lead),
    .wr_trail   (wr_trail),
    .rdy_fall   (rdy_fall),
    .rdy_rise   (rdy_rise),
    .chip_status(chip_status),
    .host_rdata (host_rdata),
    .chip_data  (chip_data),
    .chip_rs_n  (chip_rs_n),
    .chip_ws_n  (chip_ws_n),
    .overrun    (overrun)
);

// File: tb/tb_speech_bus_bridge.sv
`timescale 1ns/1ps
module tb_speech_bus_bridge;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_rd_n = 1'b1;
    logic       host_wr_n = 1'b1;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic [7:0] chip_data;
    logic       chip_rs_n, chip_ws_n, overrun, wr_idle;
    logic       chip_ready_n = 1'b1;
    logic [7:0] chip_status = 8'h00;

    int checks = 0;
    int errors = 0;
    int ovr_cnt = 0;
    int ovr_run = 0;
    int ovr_max = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    speech_bus_bridge dut (
        .clk(clk), .rst_n(rst_n), .host_rd_n(host_rd_n), .host_wr_n(host_wr_n),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .chip_data(chip_data),
        .chip_rs_n(chip_rs_n), .chip_ws_n(chip_ws_n), .chip_ready_n(chip_ready_n),
        .chip_status(chip_status), .overrun(overrun), .wr_idle(wr_idle)
    );

    always @(negedge clk) begin
        if (overrun) begin
            ovr_cnt++;
            ovr_run++;
            if (ovr_run > ovr_max) ovr_max = ovr_run;
        end else begin
            ovr_run = 0;
        end
    end

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic settle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_read(int hold, output logic [7:0] val);
        host_rd_n = 1'b0;
        settle(hold);
        val = host_rdata;
        host_rd_n = 1'b1;
        settle(6);
    endtask

    task automatic host_write(logic [7:0] b);
        host_wdata = b;
        host_wr_n = 1'b0;
        settle(6);
        host_wr_n = 1'b1;
        settle(6);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        settle(3);
        rst_n = 1'b1;
        settle(3);
    endtask

    task automatic t_reset();
        settle(2);
        check("R1 rs_n in reset", {7'd0, chip_rs_n}, 8'h01);
        check("R1 ws_n in reset", {7'd0, chip_ws_n}, 8'h01);
        do_reset();
        check("R1 rdata", host_rdata, 8'hFF);
        check("R1 chip_data", chip_data, 8'hFF);
        check("R1 overrun", {7'd0, overrun}, 8'h00);
        check("R8 wr_idle after reset", {7'd0, wr_idle}, 8'h01);
    endtask

    task automatic t_read_alternation();
        logic [7:0] v;
        chip_status = 8'hA0;
        host_read(6, v);
        check("R4 first read pullup", v, 8'hFF);
        check("R3 rs_n low after read", {7'd0, chip_rs_n}, 8'h00);
        host_read(6, v);
        check("R4 second read status", v, 8'hBF);
        check("R3 rs_n high again", {7'd0, chip_rs_n}, 8'h01);
        chip_status = 8'h40;
        host_read(6, v);
        check("R2 pullup read", v, 8'hFF);
        host_read(6, v);
        check("R2 status 0x40 forced", v, 8'h5F);
        check("R2 rdata held after read", host_rdata, 8'h5F);
    endtask

    task automatic t_long_read();
        logic [7:0] v;
        chip_status = 8'h80;
        host_read(40, v);
        check("R9 long read one capture", v, 8'hFF);
        check("R9 long read one flip", {7'd0, chip_rs_n}, 8'h00);
        host_read(6, v);
        check("R9 next read status", v, 8'h9F);
    endtask

    task automatic t_write_ready();
        int base = ovr_cnt;
        chip_ready_n = 1'b0;
        settle(6);
        check("R6 fall with nothing pending", {7'd0, chip_ws_n}, 8'h01);
        host_write(8'h5A);
        check("R5 data latched", chip_data, 8'h5A);
        check("R5 ws_n low", {7'd0, chip_ws_n}, 8'h00);
        check("R8 wr_idle low while pending", {7'd0, wr_idle}, 8'h00);
        check("R7 no overrun on first write", 8'(ovr_cnt - base), 8'h00);
        chip_ready_n = 1'b1;
        settle(6);
        check("R6 rising ready inert", {7'd0, chip_ws_n}, 8'h00);
        chip_ready_n = 1'b0;
        settle(6);
        check("R6 falling ready releases", {7'd0, chip_ws_n}, 8'h01);
        check("R6 data unchanged", chip_data, 8'h5A);
        check("R8 wr_idle high after release", {7'd0, wr_idle}, 8'h01);
        chip_ready_n = 1'b1;
        settle(6);
    endtask

    task automatic t_overrun();
        int base = ovr_cnt;
        host_write(8'h11);
        host_write(8'h22);
        check("R7 overrun one pulse", 8'(ovr_cnt - base), 8'h01);
        check("R7 pulse one cycle", 8'(ovr_max), 8'h01);
        check("R7 data replaced", chip_data, 8'h22);
        check("R7 ws_n still low", {7'd0, chip_ws_n}, 8'h00);
        chip_ready_n = 1'b0;
        settle(6);
        chip_ready_n = 1'b1;
        settle(6);
        base = ovr_cnt;
        host_write(8'h33);
        check("R7 no overrun after release", 8'(ovr_cnt - base), 8'h00);
        check("R5 data 0x33", chip_data, 8'h33);
    endtask

    task automatic t_reset_midway();
        logic [7:0] v;
        host_read(6, v);
        check("R3 rs_n low before reset", {7'd0, chip_rs_n}, 8'h00);
        do_reset();
        check("R1 rs_n preset", {7'd0, chip_rs_n}, 8'h01);
        check("R1 ws_n preset", {7'd0, chip_ws_n}, 8'h01);
        check("R1 chip_data preset", chip_data, 8'hFF);
        chip_status = 8'h00;
        host_read(6, v);
        check("R4 pullup after reset", v, 8'hFF);
        host_read(6, v);
        check("R4 status after reset", v, 8'h1F);
    endtask

    initial begin
        t_reset();
        t_read_alternation();
        t_long_read();
        t_write_ready();
        t_overrun();
        t_reset_midway();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule